// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block models the command side of a two-bank NOR flash memory. It samples the bus strobes (chip enable, write enable and output enable, all active low) together with the address and data buses once per clock. It turns bus writes into commands through a multi-cycle unlock protocol. Program, sector erase, block erase and chip erase are recognised. A completed command starts a timed busy period on the bank it addresses, and chip erase makes both banks busy. While a bank is busy, reads of that bank return a status word. Reads of the other bank keep returning stored data, so code can run from one bank while the other is being updated.

Storage is a small register array. Only the lowest few words of every sector are backed by cells. The rest of the address space reads as erased, so the full sector and block geometry is kept without a full-size memory. Busy times are parameters counted in clock cycles. A simulation can therefore shorten the program time, which stands in for a limit of about 10 µs, and the erase times.

Top module: `flash_cmd_seq`

## Requirements
- R1: A bus write is the span of clocks in which ce_n and we_n are both low. The address is taken from the first such clock and the data from the last. The write is acted on at the first clock after the span ends.
- R2: dq_oe is 1 exactly while ce_n and oe_n are both low, and dq_o is all zeros while dq_oe is 0. After reset no bank is busy and every word reads FFFFh.
- R3: A program command is four writes: AAh to 5555h, 55h to 2AAAh, A0h to 5555h, then the target address and data. Only address bits 14:0 are compared, and only data bits 7:0 carry command codes. When the command completes, the word becomes its old value AND the written data.
- R4: A sector erase is six writes: AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, then 30h at any address in the sector. When it completes, every word of that 1K-word sector (address bits 15:10) reads FFFFh and all other words are unchanged.
- R5: A block erase is the same sequence ending in 50h at any address in the block. When it completes, every word of that 32K-word block (address bit 15) reads FFFFh and all other words are unchanged.
- R6: A chip erase is the same sequence ending in 10h written to 5555h. It makes both banks busy, and when it completes every word reads FFFFh.
- R7: A write that does not match the expected next step returns the decoder to idle. A later lone address/data write then changes nothing.
- R8: The bank is address bit 15. The addressed bank is busy from the first clock after the final write ends, for exactly PROG_CYC, SERASE_CYC, BERASE_CYC or CERASE_CYC clocks. The array change appears when the busy period ends.
- R9: A read of a busy bank returns status with bits 15:8 and 5:0 zero. Bit 7 is the complement of bit 7 of the programmed data, or 0 during an erase. Bit 6 flips after every completed read access of a busy bank.
- R10: During a busy period, reads of the bank that is not busy return stored data.
- R11: Every write made while any bank is busy is ignored, including a complete command sequence.
- R12: Only word offsets 0 to 3 of each sector are stored. Other offsets read FFFFh, and programming them changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | AW | Word address |
| din | input | DW | Write data bus |
| dq_o | output | DW | Read data or status |
| dq_oe | output | 1 | Read data drive enable |

## Verification
The bench writes with staggered ce_n/we_n edges and with the address and data changing inside the write span. A decoder that latched the wrong cycle would program the wrong word or the wrong value. One read is held open across a whole program operation, so the exact clock at which status starts and array data comes back is checked. A counter off by one would show up at either end of the busy period. Broken unlock chains, a full program sequence issued during an erase, and reads of the idle bank during an erase are also checked. A design that leaked commands through busy periods or blocked the other bank would alter stored words or return status where data is expected.

// File: rtl/flash_cmd_seq.sv
`timescale 1ns/1ps
module flash_cmd_seq #(
  parameter int AW         = 16,
  parameter int DW         = 16,
  parameter int SECT_LG    = 10,
  parameter int BLK_LG     = 15,
  parameter int CELL_LG    = 2,
  parameter int PROG_CYC   = 500,
  parameter int SERASE_CYC = 2000,
  parameter int BERASE_CYC = 4000,
  parameter int CERASE_CYC = 8000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe
);
  localparam int SECT_W = AW - SECT_LG;
  localparam int BLK_W  = AW - BLK_LG;
  localparam int CELL_W = SECT_W + CELL_LG;
  localparam int NCELL  = 1 << CELL_W;
  localparam int MAX_AB = (PROG_CYC > SERASE_CYC) ? PROG_CYC : SERASE_CYC;
  localparam int MAX_CD = (BERASE_CYC > CERASE_CYC) ? BERASE_CYC : CERASE_CYC;
  localparam int MAXC   = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CNT_W  = $clog2(MAXC + 1);

  typedef enum logic [2:0] {S_IDLE, S_U1, S_U2, S_PG, S_E1, S_E2, S_E3} st_t;
  typedef enum logic [1:0] {OP_PROG, OP_SECT, OP_BLK, OP_CHIP} op_t;

  logic act, act_q, wr_end;
  logic [AW-1:0] wa;
  logic [DW-1:0] wd;
  st_t st, st_n;
  op_t op, op_n;
  logic start;
  logic [AW-1:0] op_a;
  logic [DW-1:0] op_d;
  logic [CNT_W-1:0] cnt, dur;
  logic [1:0] busy_bank;
  logic busy_any;
  logic rd, rd_busy, rdb_q, tog;
  logic [DW-1:0] mem [NCELL];

  assign act      = !ce_n && !we_n;
  assign wr_end   = act_q && !act;
  assign busy_any = |busy_bank;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      wa    <= '0;
      wd    <= '0;
    end else begin
      act_q <= act;
      if (act && !act_q) wa <= addr;
      if (act) wd <= din;
    end
  end

  logic hit_a, hit_b;
  logic [7:0] code;
  assign hit_a = wa[14:0] == 15'h5555;
  assign hit_b = wa[14:0] == 15'h2AAA;
  assign code  = wd[7:0];

  always_comb begin
    st_n  = st;
    start = 1'b0;
    op_n  = OP_PROG;
    if (wr_end && !busy_any) begin
      st_n = S_IDLE;
      case (st)
        S_IDLE: if (hit_a && code == 8'hAA) st_n = S_U1;
        S_U1:   if (hit_b && code == 8'h55) st_n = S_U2;
        S_U2: begin
          if (hit_a && code == 8'hA0) st_n = S_PG;
          else if (hit_a && code == 8'h80) st_n = S_E1;
        end
        S_PG:   start = 1'b1;
        S_E1:   if (hit_a && code == 8'hAA) st_n = S_E2;
        S_E2:   if (hit_b && code == 8'h55) st_n = S_E3;
        S_E3: begin
          if (code == 8'h30) begin
            start = 1'b1; op_n = OP_SECT;
          end else if (code == 8'h50) begin
            start = 1'b1; op_n = OP_BLK;
          end else if (code == 8'h10 && hit_a) begin
            start = 1'b1; op_n = OP_CHIP;
          end
        end
        default: st_n = S_IDLE;
      endcase
    end
  end

  always_comb begin
    case (op_n)
      OP_SECT: dur = CNT_W'(SERASE_CYC);
      OP_BLK:  dur = CNT_W'(BERASE_CYC);
      OP_CHIP: dur = CNT_W'(CERASE_CYC);
      default: dur = CNT_W'(PROG_CYC);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      op        <= OP_PROG;
      op_a      <= '0;
      op_d      <= '0;
      cnt       <= '0;
      busy_bank <= 2'b00;
    end else begin
      st <= st_n;
      if (start) begin
        op        <= op_n;
        op_a      <= wa;
        op_d      <= wd;
        cnt       <= dur;
        busy_bank <= (op_n == OP_CHIP) ? 2'b11 : (2'b01 << wa[AW-1]);
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
        if (cnt == CNT_W'(1)) busy_bank <= 2'b00;
      end
    end
  end

  logic op_backed;
  logic [CELL_W-1:0] op_idx;
  assign op_backed = op_a[SECT_LG-1:CELL_LG] == '0;
  assign op_idx    = {op_a[AW-1:SECT_LG], op_a[CELL_LG-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCELL; i++) mem[i] <= '1;
    end else if (cnt == CNT_W'(1)) begin
      if (op == OP_PROG) begin
        if (op_backed) mem[op_idx] <= mem[op_idx] & op_d;
      end else begin
        for (int i = 0; i < NCELL; i++)
          if (op == OP_CHIP ||
              (op == OP_SECT && (i >> CELL_LG) == int'(op_a[AW-1:SECT_LG])) ||
              (op == OP_BLK && (i >> (CELL_W - BLK_W)) == int'(op_a[AW-1:BLK_LG])))
            mem[i] <= '1;
      end
    end
  end

  assign rd      = !ce_n && !oe_n;
  assign rd_busy = rd && busy_bank[addr[AW-1]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdb_q <= 1'b0;
      tog   <= 1'b0;
    end else begin
      rdb_q <= rd_busy;
      if (rdb_q && !rd) tog <= ~tog;
    end
  end

  logic d7;
  logic [DW-1:0] status;
  logic rd_backed;
  logic [CELL_W-1:0] rd_idx;
  assign d7        = (op == OP_PROG) ? op_d[7] : 1'b1;
  assign status    = {{(DW-8){1'b0}}, ~d7, tog, 6'b000000};
  assign rd_backed = addr[SECT_LG-1:CELL_LG] == '0;
  assign rd_idx    = {addr[AW-1:SECT_LG], addr[CELL_LG-1:0]};
  assign dq_oe     = rd;

  always_comb begin
    if (!rd)                          dq_o = '0;
    else if (busy_bank[addr[AW-1]])   dq_o = status;
    else if (rd_backed)               dq_o = mem[rd_idx];
    else                              dq_o = '1;
  end

  assert_busy_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_any) |-> $past(wr_end));
  assert_busy_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_any) |-> $past(cnt) == CNT_W'(1));
  assert_ignore_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy_any |-> st == S_IDLE);
  assert_both_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_bank == 2'b11 |-> op == OP_CHIP);
  assert_quiet_bus_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_oe |-> dq_o == '0);
endmodule

// File: tb/test_flash_cmd_seq.sv
`timescale 1ns/1ps
module test_flash_cmd_seq;
  localparam int PC = 6, SC = 40, BC = 45, CC = 50;

  logic clk = 0, rst_n = 0;
  logic ce_n = 1, we_n = 1, oe_n = 1;
  logic [15:0] addr = '0, din = '0;
  logic [15:0] dq_o;
  logic dq_oe;
  int tests = 0, failed = 0;
  bit done = 0;
  logic [15:0] shadow [256];

  flash_cmd_seq #(.PROG_CYC(PC), .SERASE_CYC(SC), .BERASE_CYC(BC), .CERASE_CYC(CC))
    i_flash_cmd_seq (.clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
                     .addr(addr), .din(din), .dq_o(dq_o), .dq_oe(dq_oe));

  always #10 clk = ~clk;

  function automatic bit backed(logic [15:0] a);
    return a[9:2] == 8'h00;
  endfunction
  function automatic int cidx(logic [15:0] a);
    return int'({a[15:10], a[1:0]});
  endfunction
  function automatic logic [15:0] exp_rd(logic [15:0] a);
    return backed(a) ? shadow[cidx(a)] : 16'hFFFF;
  endfunction
  function automatic logic [15:0] exp_st(logic [15:0] d, bit is_prog);
    return (is_prog && !d[7]) ? 16'h0080 : 16'h0000;
  endfunction

  task automatic check(input bit ok, input string req, input logic [15:0] got, input logic [15:0] exp);
    tests++;
    if (!ok) begin
      failed++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; din = d; ce_n = 0; we_n = 0;
    @(negedge clk);
    @(negedge clk); ce_n = 1; we_n = 1;
  endtask

  task automatic bus_read(input logic [15:0] a, output logic [15:0] d, output logic oe);
    @(negedge clk); addr = a; ce_n = 0; oe_n = 0;
    #1 d = dq_o; oe = dq_oe;
    @(negedge clk); ce_n = 1; oe_n = 1;
  endtask

  task automatic unlock2();
    bus_write(16'h5555, 16'h00AA);
    bus_write(16'h2AAA, 16'h0055);
  endtask

  task automatic cmd_prog(input logic [15:0] a, input logic [15:0] d);
    unlock2();
    bus_write(16'h5555, 16'h00A0);
    bus_write(a, d);
  endtask

  task automatic cmd_erase(input logic [7:0] c, input logic [15:0] a);
    unlock2();
    bus_write(16'h5555, 16'h0080);
    unlock2();
    bus_write(a, {8'h00, c});
  endtask

  task automatic model_prog(input logic [15:0] a, input logic [15:0] d);
    if (backed(a)) shadow[cidx(a)] = shadow[cidx(a)] & d;
  endtask

  task automatic model_erase(input int kind, input logic [15:0] a);
    for (int i = 0; i < 256; i++)
      if (kind == 2 || (kind == 0 && (i >> 2) == int'(a[15:10])) || (kind == 1 && (i >> 7) == int'(a[15])))
        shadow[i] = 16'hFFFF;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic read_check(input logic [15:0] a, input string req);
    logic [15:0] v; logic oe;
    bus_read(a, v, oe);
    check(v == exp_rd(a) && oe, req, v, exp_rd(a));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; failed++;
      $display("FAIL watchdog got=%h exp=%h", 16'h0, 16'h1);
      $display("[TB] %0d tests run, %0d failed", tests, failed);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, v2, a, d;
    logic oe;
    int seed;
    seed = $urandom(32'd20240611);
    for (int i = 0; i < 256; i++) shadow[i] = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R2 reset state and output enable
    #1 check(dq_oe == 1'b0 && dq_o == 16'h0000, "R2 idle bus", dq_o, 16'h0000);
    read_check(16'h0000, "R2 reset bank0");
    read_check(16'h8003, "R2 reset bank1");
    @(negedge clk); ce_n = 0; oe_n = 1; addr = 16'h0001;
    #1 check(dq_oe == 1'b0, "R2 oe_n high", {15'h0, dq_oe}, 16'h0000);
    ce_n = 1;

    // R3 and R8: program with one read held open for the whole busy period
    cmd_prog(16'h0001, 16'h1234);
    addr = 16'h0001; ce_n = 0; oe_n = 0;
    #1 check(dq_o == exp_rd(16'h0001), "R8 before start", dq_o, exp_rd(16'h0001));
    model_prog(16'h0001, 16'h1234);
    for (int k = 1; k <= PC; k++) begin
      @(negedge clk); #1;
      check((dq_o & 16'hFFBF) == exp_st(16'h1234, 1), "R8 R9 busy status", dq_o, exp_st(16'h1234, 1));
    end
    @(negedge clk); #1;
    check(dq_o == exp_rd(16'h0001), "R8 R3 busy end data", dq_o, exp_rd(16'h0001));
    ce_n = 1; oe_n = 1;

    // R3 program ANDs with old contents
    cmd_prog(16'h0001, 16'hFF0F); model_prog(16'h0001, 16'hFF0F);
    wait_cyc(PC + 3);
    read_check(16'h0001, "R3 and old");

    // R9 bit7 complement with data bit7 = 1, R10 other bank reads data
    cmd_prog(16'h8002, 16'h00C3);
    bus_read(16'h8002, v, oe);
    check((v & 16'hFFBF) == exp_st(16'h00C3, 1), "R9 bit7 one", v, exp_st(16'h00C3, 1));
    bus_read(16'h0001, v, oe);
    check(v == exp_rd(16'h0001), "R10 other bank in program", v, exp_rd(16'h0001));
    model_prog(16'h8002, 16'h00C3);
    wait_cyc(PC + 3);
    read_check(16'h8002, "R3 bank1 program");

    // R1 staggered strobes, address first clock, data last clock
    unlock2();
    bus_write(16'h5555, 16'h00A0);
    @(negedge clk); ce_n = 0; addr = 16'h0403; din = 16'h0000;
    @(negedge clk); we_n = 0; addr = 16'h0002; din = 16'h0000;
    @(negedge clk); addr = 16'h0403; din = 16'h5A5A;
    @(negedge clk); we_n = 1; din = 16'h0000;
    @(negedge clk); ce_n = 1;
    model_prog(16'h0002, 16'h5A5A);
    wait_cyc(PC + 3);
    read_check(16'h0002, "R1 latched addr and data");
    read_check(16'h0403, "R1 other word untouched");

    // R4 sector erase, R9 toggle, R10, R11
    cmd_prog(16'h0400, 16'h0F0F); model_prog(16'h0400, 16'h0F0F);
    wait_cyc(PC + 3);
    cmd_erase(8'h30, 16'h0001);
    bus_read(16'h0002, v, oe);
    bus_read(16'h0003, v2, oe);
    check((v & 16'hFFBF) == 16'h0000, "R9 erase status", v, 16'h0000);
    check(v[6] != v2[6], "R9 toggle", v2, {v[15:7], ~v[6], v[5:0]});
    bus_read(16'h8002, v, oe);
    check(v == exp_rd(16'h8002), "R10 other bank in erase", v, exp_rd(16'h8002));
    cmd_prog(16'h8001, 16'h0000);
    model_erase(0, 16'h0001);
    wait_cyc(SC + 3);
    read_check(16'h0001, "R4 sector erased");
    read_check(16'h0002, "R4 sector erased b");
    read_check(16'h0400, "R4 next sector kept");
    read_check(16'h8001, "R11 ignored while busy");

    // R7 mismatches
    unlock2();
    bus_write(16'h1234, 16'h00A0);
    bus_write(16'h0003, 16'h0000);
    wait_cyc(PC + 3);
    read_check(16'h0003, "R7 bad third address");
    unlock2();
    bus_write(16'h5555, 16'h0080);
    bus_write(16'h5555, 16'h00AA);
    bus_write(16'h2AAA, 16'h0056);
    bus_write(16'h0400, 16'h0030);
    wait_cyc(SC + 3);
    read_check(16'h0400, "R7 bad erase chain");
    cmd_prog(16'h0003, 16'h00F0); model_prog(16'h0003, 16'h00F0);
    wait_cyc(PC + 3);
    read_check(16'h0003, "R7 recovers");

    // R12 unbacked offset
    cmd_prog(16'h0410, 16'h0000);
    wait_cyc(PC + 3);
    read_check(16'h0410, "R12 unbacked");

    // Random mix of programs and reads
    for (int n = 0; n < 60; n++) begin
      a = 16'($urandom);
      if ($urandom % 4 != 0) a[9:2] = 8'h00;
      d = 16'($urandom);
      if ($urandom % 3 != 0) begin
        cmd_prog(a, d); model_prog(a, d);
        wait_cyc(PC + 3);
        read_check(a, "R3 random program");
      end else begin
        read_check(a, "R12 random read");
      end
    end

    // R5 block erase
    cmd_prog(16'h0001, 16'h0000); model_prog(16'h0001, 16'h0000);
    wait_cyc(PC + 3);
    cmd_erase(8'h50, 16'h8123);
    bus_read(16'h0001, v, oe);
    check(v == exp_rd(16'h0001), "R10 other bank in block erase", v, exp_rd(16'h0001));
    model_erase(1, 16'h8123);
    wait_cyc(BC + 3);
    read_check(16'h8002, "R5 block erased");
    read_check(16'hFC03, "R5 block erased top");
    read_check(16'h0001, "R5 other block kept");

    // R6 chip erase
    cmd_erase(8'h10, 16'h5555);
    bus_read(16'h0001, v, oe);
    check((v & 16'hFFBF) == 16'h0000, "R6 bank0 busy", v, 16'h0000);
    bus_read(16'h8001, v, oe);
    check((v & 16'hFFBF) == 16'h0000, "R6 bank1 busy", v, 16'h0000);
    model_erase(2, 16'h0000);
    wait_cyc(CC + 3);
    read_check(16'h0001, "R6 chip erased");
    read_check(16'h0002, "R6 chip erased b");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end
endmodule